// File: doc/BRIEF.md
# Transactional Line Buffer with Dual Versions

This block is a small, fully associative store that sits beside a core's first-level data cache. It holds every line that a hardware transaction touches. Ordinary loads and stores bypass it and go to the regular cache. Transactional loads and stores are served here. Each entry keeps an address tag, the value the line had before the transaction (the old copy), and the value the transaction has built up so far (the new copy).

The core opens a transaction with a begin command, then ends it with either a commit or an abort. A commit publishes every written line at once: in the cycle after the commit, the buffer presents all written lines on a write-back bus. An abort, whether the core asks for it or the buffer triggers it, throws away every new copy at once. The buffer triggers an abort itself in two cases. The first is a conflicting coherence snoop from another core. The second is a transaction that needs more lines than the buffer holds. When the buffer aborts, it raises a sticky abort request so that software can retry, possibly in a software-only mode.

Top module: `txn_line_buf`

## Requirements
- R1: After reset, busy, abort_req, ovf_flag and wb_valid are all low. A begin command while no transaction is open raises busy one clock later and clears abort_req and ovf_flag. A begin while a transaction is open is ignored.
- R2: The first transactional store to a line allocates an entry with old copy = acc_cur and new copy = acc_wdata. Later stores to that line change only the new copy. A transactional load returns the new copy on rd_data in the same cycle on a hit, and acc_cur on a miss. A load miss allocates an entry with both copies equal to acc_cur.
- R3: A commit writes back the written entries in the next cycle. For one cycle, wb_valid bit i is set for each entry i that was written. wb_tag and wb_data slice i (bits i*W up) carry that entry's tag and new copy. Lines that were only read are not flagged. Entries are allocated at the lowest free index first, starting from entry 0.
- R4: An explicit abort discards all new copies. wb_valid stays zero, busy falls and abort_req rises one clock later. Lines the aborted transaction stored later miss and return acc_cur.
- R5: A snoop whose tag matches a written entry aborts the transaction on any request type. In the snoop cycle, snp_hit is high and snp_data shows the old copy.
- R6: A snoop that matches a line that has only been read aborts the transaction only when snp_excl (write or ownership request) is high. Otherwise it is ignored.
- R7: A snoop that matches no valid entry, or arrives while no transaction is open, gives snp_hit low and has no effect.
- R8: With ENTRIES distinct lines the transaction continues. An access to one more distinct line aborts it and sets both ovf_flag and abort_req.
- R9: abort_req and ovf_flag hold until the next begin command. A commit while they are set produces no write-back.
- R10: Outside a transaction, accesses and commits are ignored: nothing is allocated and nothing is written back.
- R11: After a commit or abort, every entry is invalid, and a begin is accepted in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_begin | input | 1 | Open a transaction |
| cmd_commit | input | 1 | Commit the open transaction |
| cmd_abort | input | 1 | Explicit abort request from the core |
| acc_valid | input | 1 | Transactional access this cycle |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_tag | input | TAG_W | Line address of the access |
| acc_wdata | input | DATA_W | Store data for the line |
| acc_cur | input | DATA_W | Current committed value of the line |
| rd_data | output | DATA_W | Load result (combinational) |
| snp_valid | input | 1 | Incoming coherence snoop |
| snp_excl | input | 1 | Snoop is a write or ownership request |
| snp_tag | input | TAG_W | Snooped line address |
| snp_hit | output | 1 | Snoop matches a valid entry (combinational) |
| snp_data | output | DATA_W | Old copy of the matching entry |
| busy | output | 1 | Transaction open |
| abort_req | output | 1 | Sticky abort request to the core |
| ovf_flag | output | 1 | Sticky capacity-overflow cause |
| wb_valid | output | ENTRIES | One-cycle commit mask, bit per entry |
| wb_tag | output | ENTRIES*TAG_W | Committed tags, slice per entry |
| wb_data | output | ENTRIES*DATA_W | Committed new copies, slice per entry |

## Verification
rd_data, snp_hit and snp_data are combinational, so they are due in the same cycle as the stimulus. busy, abort_req, ovf_flag and the write-back bus are due after the next rising edge. The bench drives each stimulus just after a falling edge and samples the combinational results 1 ns later. It then checks the registered results at the next falling edge, one rising edge after the stimulus. Sticky flags are sampled again after idle cycles.

// File: rtl/txn_line_buf.sv
module txn_line_buf #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 32,
  parameter int DATA_W  = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_begin,
  input  logic                      cmd_commit,
  input  logic                      cmd_abort,
  input  logic                      acc_valid,
  input  logic                      acc_write,
  input  logic [TAG_W-1:0]          acc_tag,
  input  logic [DATA_W-1:0]         acc_wdata,
  input  logic [DATA_W-1:0]         acc_cur,
  output logic [DATA_W-1:0]         rd_data,
  input  logic                      snp_valid,
  input  logic                      snp_excl,
  input  logic [TAG_W-1:0]          snp_tag,
  output logic                      snp_hit,
  output logic [DATA_W-1:0]         snp_data,
  output logic                      busy,
  output logic                      abort_req,
  output logic                      ovf_flag,
  output logic [ENTRIES-1:0]        wb_valid,
  output logic [ENTRIES*TAG_W-1:0]  wb_tag,
  output logic [ENTRIES*DATA_W-1:0] wb_data
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [TAG_W-1:0]  tag_q [ENTRIES];
  logic [DATA_W-1:0] old_q [ENTRIES];
  logic [DATA_W-1:0] new_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q, wr_q;
  logic in_tx, abrt_q, ovf_q;

  logic hit_any, free_any, snp_any;
  logic [IDX_W-1:0] hit_idx, free_idx, snp_idx;

  always_comb begin
    hit_any = 1'b0; hit_idx = '0;
    snp_any = 1'b0; snp_idx = '0;
    free_any = 1'b0; free_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (valid_q[i] && tag_q[i] == acc_tag && !hit_any) begin
        hit_any = 1'b1; hit_idx = IDX_W'(i);
      end
      if (valid_q[i] && tag_q[i] == snp_tag && !snp_any) begin
        snp_any = 1'b1; snp_idx = IDX_W'(i);
      end
    end
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        free_any = 1'b1; free_idx = IDX_W'(i);
      end
    end
  end

  wire acc_go    = acc_valid && in_tx;
  wire ovf_hit   = acc_go && !hit_any && !free_any;
  wire snp_go    = snp_valid && in_tx && snp_any;
  wire conflict  = snp_go && (wr_q[snp_idx] || snp_excl);
  wire kill      = in_tx && (cmd_abort || conflict || ovf_hit);
  wire do_commit = in_tx && cmd_commit && !kill;
  wire do_begin  = cmd_begin && !in_tx;

  assign rd_data   = (in_tx && hit_any) ? new_q[hit_idx] : acc_cur;
  assign snp_hit   = snp_go;
  assign snp_data  = old_q[snp_idx];
  assign busy      = in_tx;
  assign abort_req = abrt_q;
  assign ovf_flag  = ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= '0;
      wr_q     <= '0;
      in_tx    <= 1'b0;
      abrt_q   <= 1'b0;
      ovf_q    <= 1'b0;
      wb_valid <= '0;
    end else begin
      wb_valid <= '0;
      if (kill) begin
        valid_q <= '0;
        in_tx   <= 1'b0;
        abrt_q  <= 1'b1;
        if (ovf_hit) ovf_q <= 1'b1;
      end else if (do_commit) begin
        valid_q  <= '0;
        in_tx    <= 1'b0;
        wb_valid <= valid_q & wr_q;
      end else if (do_begin) begin
        in_tx  <= 1'b1;
        abrt_q <= 1'b0;
        ovf_q  <= 1'b0;
      end else if (acc_go) begin
        if (hit_any) begin
          if (acc_write) wr_q[hit_idx] <= 1'b1;
        end else begin
          valid_q[free_idx] <= 1'b1;
          wr_q[free_idx]    <= acc_write;
        end
      end
    end
  end

  wire acc_store = acc_go && !kill && !do_commit && !do_begin;

  always_ff @(posedge clk) begin
    if (acc_store) begin
      if (hit_any) begin
        if (acc_write) new_q[hit_idx] <= acc_wdata;
      end else begin
        tag_q[free_idx] <= acc_tag;
        old_q[free_idx] <= acc_cur;
        new_q[free_idx] <= acc_write ? acc_wdata : acc_cur;
      end
    end
    if (do_commit) begin
      for (int i = 0; i < ENTRIES; i++) begin
        wb_tag[i*TAG_W +: TAG_W]    <= tag_q[i];
        wb_data[i*DATA_W +: DATA_W] <= new_q[i];
      end
    end
  end

  // R3
  wb_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wb_valid) |-> $past(busy && cmd_commit));

  // R11
  end_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (cmd_commit || cmd_abort)) |=> (!busy && valid_q == '0));

  // R9
  abort_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_req && !cmd_begin) |=> abort_req);

  // R8
  ovf_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |-> abort_req);

  // R5
  excl_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hit && snp_excl) |=> (abort_req && !busy));

  // R10
  idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_begin) |=> (valid_q == '0 && !busy));
endmodule

// File: tb/txn_line_buf_tb_top.sv
module txn_line_buf_tb_top;
  localparam int ENTRIES = 8;
  localparam int TAG_W   = 32;
  localparam int DATA_W  = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_begin = 0, cmd_commit = 0, cmd_abort = 0;
  logic acc_valid = 0, acc_write = 0;
  logic [TAG_W-1:0]  acc_tag = '0, snp_tag = '0;
  logic [DATA_W-1:0] acc_wdata = '0, acc_cur = '0;
  logic snp_valid = 0, snp_excl = 0;
  logic [DATA_W-1:0] rd_data, snp_data;
  logic snp_hit, busy, abort_req, ovf_flag;
  logic [ENTRIES-1:0] wb_valid;
  logic [ENTRIES*TAG_W-1:0] wb_tag;
  logic [ENTRIES*DATA_W-1:0] wb_data;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  txn_line_buf #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_begin(cmd_begin), .cmd_commit(cmd_commit),
    .cmd_abort(cmd_abort), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_tag(acc_tag), .acc_wdata(acc_wdata), .acc_cur(acc_cur), .rd_data(rd_data),
    .snp_valid(snp_valid), .snp_excl(snp_excl), .snp_tag(snp_tag), .snp_hit(snp_hit),
    .snp_data(snp_data), .busy(busy), .abort_req(abort_req), .ovf_flag(ovf_flag),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cmd(input int kind);
    cmd_begin = (kind == 0); cmd_commit = (kind == 1); cmd_abort = (kind == 2);
    @(negedge clk);
    cmd_begin = 0; cmd_commit = 0; cmd_abort = 0;
  endtask

  task automatic access(input bit wr, input logic [31:0] t, input logic [63:0] cur,
                        input logic [63:0] wd, output logic [63:0] rd);
    acc_valid = 1; acc_write = wr; acc_tag = t; acc_cur = cur; acc_wdata = wd;
    #1 rd = rd_data;
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
  endtask

  task automatic snoop(input bit ex, input logic [31:0] t, output logic h,
                       output logic [63:0] d);
    snp_valid = 1; snp_excl = ex; snp_tag = t;
    #1 begin h = snp_hit; d = snp_data; end
    @(negedge clk);
    snp_valid = 0; snp_excl = 0;
  endtask

  task automatic t_versions_commit();
    logic [63:0] r; logic h;
    cmd(0);
    chk("R1 busy after begin", busy, 1);
    access(1, 32'hA0, 64'h11, 64'h22, r);
    access(0, 32'hA0, 64'h99, 0, r);
    chk("R2 load returns new copy", r, 64'h22);
    access(1, 32'hA0, 64'h99, 64'h33, r);
    access(0, 32'hB0, 64'h55, 0, r);
    chk("R2 load miss returns current", r, 64'h55);
    snoop(0, 32'hB0, h, r);
    chk("R6 shared snoop read-only hit", h, 1);
    chk("R6 no abort on shared snoop", abort_req, 0);
    cmd(1);
    chk("R3 commit mask", wb_valid, 8'h01);
    chk("R3 commit tag", wb_tag[0 +: 32], 32'hA0);
    chk("R3 commit data", wb_data[0 +: 64], 64'h33);
    chk("R11 busy low after commit", busy, 0);
    @(negedge clk);
    chk("R3 mask is one cycle", wb_valid, 0);
  endtask

  task automatic t_back_to_back();
    logic [63:0] r;
    cmd(0);
    access(1, 32'hC0, 0, 64'h1, r);
    cmd(1);
    cmd(0);
    chk("R11 begin right after commit", busy, 1);
    access(0, 32'hC0, 64'h77, 0, r);
    chk("R11 entries cleared", r, 64'h77);
    cmd(1);
  endtask

  task automatic t_abort();
    logic [63:0] r;
    cmd(0);
    access(1, 32'hD0, 64'h4, 64'hAA, r);
    cmd(2);
    chk("R4 abort_req after abort", abort_req, 1);
    chk("R4 no write-back", wb_valid, 0);
    chk("R4 busy low", busy, 0);
    chk("R4 explicit abort no ovf", ovf_flag, 0);
    cmd(0);
    chk("R1 begin clears abort_req", abort_req, 0);
    access(0, 32'hD0, 64'h5, 0, r);
    chk("R4 discarded line misses", r, 64'h5);
    cmd(1);
  endtask

  task automatic t_snoops();
    logic [63:0] r; logic h;
    cmd(0);
    access(1, 32'hE0, 64'h1, 64'h2, r);
    snoop(1, 32'hE4, h, r);
    chk("R7 non-matching snoop miss", h, 0);
    chk("R7 no abort", abort_req, 0);
    snoop(0, 32'hE0, h, r);
    chk("R5 snoop hit on written", h, 1);
    chk("R2 snoop sees old copy", r, 64'h1);
    chk("R5 abort on shared snoop to written", abort_req, 1);
    cmd(0);
    access(0, 32'hF0, 64'h8, 0, r);
    snoop(1, 32'hF0, h, r);
    chk("R6 exclusive snoop on read line aborts", abort_req, 1);
    snoop(1, 32'hF0, h, r);
    chk("R7 snoop outside tx no hit", h, 0);
  endtask

  task automatic t_overflow();
    logic [63:0] r;
    cmd(0);
    for (int i = 0; i < ENTRIES; i++) access(0, 32'h100 + i, i, 0, r);
    chk("R8 full buffer no abort", abort_req, 0);
    access(1, 32'h200, 0, 64'h9, r);
    chk("R8 overflow abort", abort_req, 1);
    chk("R8 overflow flag", ovf_flag, 1);
    repeat (3) @(negedge clk);
    cmd(1);
    chk("R9 abort_req sticky", abort_req, 1);
    chk("R9 ovf_flag sticky", ovf_flag, 1);
    chk("R9 commit ignored", wb_valid, 0);
    cmd(0);
    chk("R9 begin clears ovf", ovf_flag, 0);
    cmd(1);
  endtask

  task automatic t_idle();
    logic [63:0] r;
    access(1, 32'h300, 64'h6, 64'h7, r);
    cmd(1);
    chk("R10 commit outside tx", wb_valid, 0);
    cmd(0);
    access(0, 32'h300, 64'h6, 0, r);
    chk("R10 idle store not kept", r, 64'h6);
    cmd(0);
    chk("R1 begin while open ignored", busy, 1);
    cmd(1);
    chk("R10 read-only commit empty", wb_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset abort_req", abort_req, 0);
    chk("R1 reset ovf", ovf_flag, 0);
    chk("R1 reset wb", wb_valid, 0);
    rst_n = 1;
    @(negedge clk);
    t_versions_commit();
    t_back_to_back();
    t_abort();
    t_snoops();
    t_overflow();
    t_idle();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule